// File: doc/BRIEF.md
# Same-Line Load Batch Selector

This block schedules memory operations out of a circular queue of `N` entries. Each cycle it looks at the oldest entry. If that entry is a ready operation of the gathered kind (loads by default), it is granted execution port 0. The block then collects further ready operations of that kind that fall in the same cache line as the head. These go, in queue order, to ports 1, 2 and so on, up to `P` ports in total. The gather ends at the first fence, the first atomic read-modify-write, or the first entry of the opposite kind that touches the head's cache line. Nothing behind that point is granted in that cycle.

Granted entries are not shifted out of the queue. They are flagged as removed, and the head pointer jumps over any leading run of removed entries in the same cycle. Port numbers come from a parallel prefix network with logarithmic depth. The network counts eligible entries before the first barrier. One multiplexer per port then copies the granted entry's address, size and tag into a registered pipeline slot. A fence or atomic at the head leaves on port 0, and only when the peer queue reports that the same barrier is at its own head.

The `GATHER_KIND` parameter selects which kind is gathered, so the same block also serves as the store-side scheduler.

Top module: `line_batch_sched`

## Requirements
- R1: A gather happens only when the head entry is a ready entry of the gathered kind. The head entry then appears on port 0 one cycle after the selection cycle. If the head is not ready, no port is valid.
- R2: Besides the head, only ready entries of the gathered kind whose address bits above `LINE_OFS` equal the head's are granted. Their tags appear on ascending ports in queue order.
- R3: A fence (kind 2), an atomic (kind 3), or an entry of the opposite kind (store, kind 1, when loads, kind 0, are gathered) in the head's line stops the gather. No entry after it is granted that cycle.
- R4: If more than `P` entries qualify, the first `P` in queue order are granted. The rest are granted in a later cycle. Valid ports always form a contiguous group starting at port 0.
- R5: A granted entry is marked removed and is never granted again, including when the head later passes it.
- R6: In the same cycle as a grant, the head advances past every leading removed entry. `q_count` reports the remaining span from head to tail.
- R7: A fence or atomic at the head that is ready is issued alone on port 0, with its kind on `port_kind`, only while `peer_at_barrier` is 1. Until then nothing is issued.
- R8: An enqueue while `q_count` equals `N` is dropped. `q_count` never exceeds `N`.
- R9: After reset, `q_count` is 0 and no port is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Append one entry at the tail |
| enq_kind | input | 2 | 0 load, 1 store, 2 fence, 3 atomic |
| enq_ready | input | 1 | Entry is ready on arrival |
| enq_addr | input | ADDR_W | Byte address |
| enq_size | input | 2 | Access size code, carried through |
| enq_tag | input | TAG_W | Identifier, carried through |
| ready_set | input | N | Sets the ready flag of physical slot i |
| peer_at_barrier | input | 1 | The other queue's head holds the same barrier |
| q_count | output | $clog2(N)+1 | Entries from head to tail |
| port_valid | output | P | Port p carries an operation |
| port_kind | output | 2*P | Kind per port, port p at bits [2p+1:2p] |
| port_addr | output | P*ADDR_W | Address per port |
| port_size | output | 2*P | Size per port |
| port_tag | output | P*TAG_W | Tag per port |

## Verification
Granting a batch and retiring the head can collide in one cycle. This happens when the head advance has to cross both entries granted in that same cycle and entries removed several cycles earlier. To force it, a directed case grants the head and a later same-line entry around an entry from another line. In the next cycle that other-line entry becomes the head and is granted alone. The bench then requires `q_count` to drop straight to zero and the already-removed entry never to reappear on a port. A barrier that blocks the gather while port saturation also spills entries is covered as well. That case is judged against a serial head-to-tail reference scan over random queue contents.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

  typedef enum logic [1:0] {
    OPK_LOAD   = 2'd0,
    OPK_STORE  = 2'd1,
    OPK_FENCE  = 2'd2,
    OPK_ATOMIC = 2'd3
  } op_kind_e;

  // Fences and atomics both carry bit 1 of the kind code.
  function automatic logic is_barrier_kind(logic [1:0] k);
    return k[1];
  endfunction

  // Count addition that sticks at cap once reached.
  function automatic int sat_add(int a, int b, int cap);
    return (a + b > cap) ? cap : a + b;
  endfunction

endpackage

// File: rtl/lbs_prefix_net.sv
// Inclusive prefix over (barrier seen, eligible count) pairs, in
// log2(N) combining levels. The count only accumulates until the first barrier.
module lbs_prefix_net #(
  parameter int N   = 16,
  parameter int CW  = 3,
  parameter int CAP = 5
) (
  input  logic [N-1:0]    bar_in,
  input  logic [N-1:0]    cand_in,
  output logic [N-1:0]    bar_out,
  output logic [N*CW-1:0] cnt_out
);
  localparam int L = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  bar_l [L+1];
  logic [CW-1:0] cnt_l [L+1][N];

  for (genvar k = 0; k < N; k++) begin : g_leaf
    assign bar_l[0][k] = bar_in[k];
    assign cnt_l[0][k] = CW'(cand_in[k] & ~bar_in[k]);
  end

  for (genvar lv = 0; lv < L; lv++) begin : g_lvl
    localparam int D = 1 << lv;
    for (genvar k = 0; k < N; k++) begin : g_node
      if (k >= D) begin : g_comb
        assign bar_l[lv+1][k] = bar_l[lv][k-D] | bar_l[lv][k];
        assign cnt_l[lv+1][k] = bar_l[lv][k-D] ? cnt_l[lv][k-D] :
          CW'(lbs_pkg::sat_add(int'(cnt_l[lv][k-D]), int'(cnt_l[lv][k]), CAP));
      end else begin : g_pass
        assign bar_l[lv+1][k] = bar_l[lv][k];
        assign cnt_l[lv+1][k] = cnt_l[lv][k];
      end
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_out
    assign bar_out[k]           = bar_l[L][k];
    assign cnt_out[k*CW +: CW]  = cnt_l[L][k];
  end
endmodule

// File: rtl/lbs_port_mux.sv
// One execution port's field selector over the head-relative queue order.
module lbs_port_mux #(
  parameter int N       = 16,
  parameter int PW      = 2,
  parameter int FW      = 40,
  parameter int PORT_ID = 0
) (
  input  logic [N-1:0]    grant,
  input  logic [N*PW-1:0] port_idx,
  input  logic [N*FW-1:0] payload,
  output logic            hit,
  output logic [FW-1:0]   data
);
  always_comb begin
    hit  = 1'b0;
    data = '0;
    for (int k = 0; k < N; k++) begin
      if (grant[k] && port_idx[k*PW +: PW] == PW'(PORT_ID)) begin
        hit  = 1'b1;
        data = data | payload[k*FW +: FW];
      end
    end
  end
endmodule

// File: rtl/line_batch_sched.sv
module line_batch_sched #(
  parameter int N           = 16,
  parameter int P           = 4,
  parameter int ADDR_W      = 32,
  parameter int LINE_OFS    = 6,
  parameter int TAG_W       = 6,
  parameter int GATHER_KIND = 0,
  localparam int IW = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enq_valid,
  input  logic [1:0]          enq_kind,
  input  logic                enq_ready,
  input  logic [ADDR_W-1:0]   enq_addr,
  input  logic [1:0]          enq_size,
  input  logic [TAG_W-1:0]    enq_tag,
  input  logic [N-1:0]        ready_set,
  input  logic                peer_at_barrier,
  output logic [IW:0]         q_count,
  output logic [P-1:0]        port_valid,
  output logic [2*P-1:0]      port_kind,
  output logic [P*ADDR_W-1:0] port_addr,
  output logic [2*P-1:0]      port_size,
  output logic [P*TAG_W-1:0]  port_tag
);
  import lbs_pkg::*;

  localparam int CW     = $clog2(P + 2);
  localparam int PW     = (P > 1) ? $clog2(P) : 1;
  localparam int FW     = ADDR_W + 2 + TAG_W;
  localparam int LINE_W = ADDR_W - LINE_OFS;
  localparam logic [1:0] K_GATHER = 2'(GATHER_KIND);
  localparam logic [1:0] K_OTHER  = (GATHER_KIND == 0) ? OPK_STORE : OPK_LOAD;

  // Physical queue storage
  logic [1:0]        kind_q [N];
  logic [ADDR_W-1:0] addr_q [N];
  logic [1:0]        size_q [N];
  logic [TAG_W-1:0]  tag_q  [N];
  logic [N-1:0]      rdy_q, rem_q;
  logic [IW-1:0]     head_q;
  logic [IW:0]       cnt_q;

  // Head-relative view
  logic [IW-1:0]     phys_rel [N];
  logic [N-1:0]      in_rng, cand_rel, bar_rel;
  logic [1:0]        kind_rel [N];
  logic [N-1:0]      rdy_rel;
  logic [N*FW-1:0]   pay_rel;
  logic [LINE_W-1:0] head_line;

  // Named events for the checker
  logic              head_go, bar_go;
  logic [N-1:0]      grant_rel, taken_rel;
  logic [IW:0]       head_skip;
  logic [N-1:0]      rem_next;
  logic [IW-1:0]     tail;
  logic              enq_ok;

  logic [N-1:0]      incl_bar;
  logic [N*CW-1:0]   incl_cnt;
  logic [N*PW-1:0]   port_rel;

  assign head_line = addr_q[head_q][ADDR_W-1:LINE_OFS];

  always_comb begin
    for (int k = 0; k < N; k++) begin
      phys_rel[k] = head_q + IW'(k);
      in_rng[k]   = (IW+1)'(k) < cnt_q;
      kind_rel[k] = kind_q[phys_rel[k]];
      rdy_rel[k]  = rdy_q[phys_rel[k]];
      pay_rel[k*FW +: FW] = {addr_q[phys_rel[k]], size_q[phys_rel[k]], tag_q[phys_rel[k]]};
      cand_rel[k] = in_rng[k] & ~rem_q[phys_rel[k]] & (kind_rel[k] == K_GATHER) & rdy_rel[k] &
                    (addr_q[phys_rel[k]][ADDR_W-1:LINE_OFS] == head_line);
      bar_rel[k]  = in_rng[k] & ~rem_q[phys_rel[k]] &
                    (is_barrier_kind(kind_rel[k]) |
                     ((kind_rel[k] == K_OTHER) &
                      (addr_q[phys_rel[k]][ADDR_W-1:LINE_OFS] == head_line)));
    end
  end

  // The head entry is always live: the head pointer never rests on a removed slot.
  assign head_go = (cnt_q != '0) & (kind_rel[0] == K_GATHER) & rdy_rel[0];
  assign bar_go  = (cnt_q != '0) & is_barrier_kind(kind_rel[0]) & rdy_rel[0] & peer_at_barrier;

  lbs_prefix_net #(.N(N), .CW(CW), .CAP(P + 1)) u_prefix (
    .bar_in (bar_rel),
    .cand_in(cand_rel),
    .bar_out(incl_bar),
    .cnt_out(incl_cnt)
  );

  always_comb begin
    for (int k = 0; k < N; k++) begin
      grant_rel[k] = head_go & cand_rel[k] & ~incl_bar[k] &
                     (incl_cnt[k*CW +: CW] <= CW'(P));
      port_rel[k*PW +: PW] = PW'(incl_cnt[k*CW +: CW] - CW'(1));
    end
    taken_rel    = grant_rel;
    taken_rel[0] = grant_rel[0] | bar_go;
  end

  // Leading run of removed entries, then the removed-flag update.
  always_comb begin
    logic run;
    run       = 1'b1;
    head_skip = '0;
    for (int k = 0; k < N; k++) begin
      run       = run & in_rng[k] & (rem_q[phys_rel[k]] | taken_rel[k]);
      head_skip = head_skip + (IW+1)'(run);
    end
    rem_next = rem_q;
    for (int k = 0; k < N; k++) begin
      if (taken_rel[k])                 rem_next[phys_rel[k]] = 1'b1;
      if ((IW+1)'(k) < head_skip)       rem_next[phys_rel[k]] = 1'b0;
    end
  end

  assign enq_ok = enq_valid & (cnt_q != (IW+1)'(N));
  assign tail   = head_q + cnt_q[IW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      cnt_q  <= '0;
      rdy_q  <= '0;
      rem_q  <= '0;
    end else begin
      head_q <= head_q + head_skip[IW-1:0];
      cnt_q  <= cnt_q - head_skip + (IW+1)'(enq_ok);
      rdy_q  <= rdy_q | ready_set;
      rem_q  <= rem_next;
      if (enq_ok) begin
        rdy_q[tail] <= enq_ready;
        rem_q[tail] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (enq_ok) begin
      kind_q[tail] <= enq_kind;
      addr_q[tail] <= enq_addr;
      size_q[tail] <= enq_size;
      tag_q[tail]  <= enq_tag;
    end
  end

  // Per-port selection and pipeline slot registers
  logic [P-1:0]    hit;
  logic [FW-1:0]   mux_data [P];
  logic [P-1:0]    slot_valid;
  logic [FW-1:0]   slot_pay  [P];
  logic [1:0]      slot_kind [P];

  for (genvar p = 0; p < P; p++) begin : g_port
    lbs_port_mux #(.N(N), .PW(PW), .FW(FW), .PORT_ID(p)) u_mux (
      .grant   (grant_rel),
      .port_idx(port_rel),
      .payload (pay_rel),
      .hit     (hit[p]),
      .data    (mux_data[p])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_valid[p] <= 1'b0;
        slot_pay[p]   <= '0;
        slot_kind[p]  <= '0;
      end else if (p == 0 && bar_go) begin
        slot_valid[p] <= 1'b1;
        slot_pay[p]   <= pay_rel[FW-1:0];
        slot_kind[p]  <= kind_rel[0];
      end else begin
        slot_valid[p] <= hit[p];
        slot_pay[p]   <= mux_data[p];
        slot_kind[p]  <= K_GATHER;
      end
    end

    assign port_valid[p]                 = slot_valid[p];
    assign port_kind[2*p +: 2]           = slot_kind[p];
    assign port_addr[p*ADDR_W +: ADDR_W] = slot_pay[p][FW-1 -: ADDR_W];
    assign port_size[2*p +: 2]           = slot_pay[p][TAG_W +: 2];
    assign port_tag[p*TAG_W +: TAG_W]    = slot_pay[p][TAG_W-1:0];
  end

  assign q_count = cnt_q;
endmodule

// File: rtl/lbs_sched_chk.sv
module lbs_sched_chk #(
  parameter int NQ       = 16,
  parameter int P        = 4,
  parameter int ADDR_W   = 32,
  parameter int LINE_OFS = 6,
  parameter int IW       = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                head_go,
  input logic                bar_go,
  input logic [IW:0]         head_skip,
  input logic [IW:0]         q_count,
  input logic [P-1:0]        port_valid,
  input logic [1:0]          port0_kind,
  input logic [P*ADDR_W-1:0] port_addr
);
  function automatic logic lines_agree(logic [P-1:0] v, logic [P*ADDR_W-1:0] a);
    logic ok;
    ok = 1'b1;
    for (int p = 1; p < P; p++)
      if (v[p] && (((a[p*ADDR_W +: ADDR_W] ^ a[ADDR_W-1:0]) >> LINE_OFS) != '0))
        ok = 1'b0;
    return ok;
  endfunction

  // R1
  ports_need_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!head_go && !bar_go) |=> (port_valid == '0));

  // R2
  same_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_valid[0] |-> lines_agree(port_valid, port_addr));

  // R4
  port_pack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((port_valid & (port_valid + P'(1))) == '0));

  // R6
  head_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (head_go || bar_go) |-> (head_skip != '0));

  // R7
  bar_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bar_go |=> ((port_valid == P'(1)) && (port0_kind == 2'd2 || port0_kind == 2'd3)));

  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= (IW+1)'(NQ));
endmodule

bind line_batch_sched lbs_sched_chk #(
  .NQ(N), .P(P), .ADDR_W(ADDR_W), .LINE_OFS(LINE_OFS), .IW(IW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .head_go   (head_go),
  .bar_go    (bar_go),
  .head_skip (head_skip),
  .q_count   (q_count),
  .port_valid(port_valid),
  .port0_kind(port_kind[1:0]),
  .port_addr (port_addr)
);

// File: tb/tb_line_batch_sched.sv
module tb_line_batch_sched;
  localparam int N = 16, P = 4, AW = 32, TW = 6, IW = 4;
  localparam int K_LD = 0, K_ST = 1, K_FN = 2, K_AT = 3;
  localparam int LA = 5, LB = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic           enq_valid = 1'b0;
  logic [1:0]     enq_kind = '0;
  logic           enq_ready = 1'b0;
  logic [AW-1:0]  enq_addr = '0;
  logic [1:0]     enq_size = '0;
  logic [TW-1:0]  enq_tag = '0;
  logic [N-1:0]   ready_set = '0;
  logic           peer_at_barrier = 1'b0;
  logic [IW:0]    q_count;
  logic [P-1:0]   port_valid;
  logic [2*P-1:0] port_kind;
  logic [P*AW-1:0] port_addr;
  logic [2*P-1:0] port_size;
  logic [P*TW-1:0] port_tag;

  line_batch_sched dut (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_kind(enq_kind),
    .enq_ready(enq_ready), .enq_addr(enq_addr), .enq_size(enq_size), .enq_tag(enq_tag),
    .ready_set(ready_set), .peer_at_barrier(peer_at_barrier), .q_count(q_count),
    .port_valid(port_valid), .port_kind(port_kind), .port_addr(port_addr),
    .port_size(port_size), .port_tag(port_tag)
  );

  int total = 0, bad = 0;
  int m_kind [N];
  logic [AW-1:0] m_addr [N];
  int m_n;

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    enq_valid = 0; ready_set = '0; peer_at_barrier = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    m_n = 0;
    @(negedge clk);
  endtask

  task automatic enq(int kind, int line, bit rdy);
    enq_valid = 1;
    enq_kind  = 2'(kind);
    enq_ready = rdy;
    enq_addr  = (AW'(line) << 6) | AW'((m_n * 4) % 64);
    enq_size  = 2'(m_n);
    enq_tag   = TW'(m_n);
    if (m_n < N) begin
      m_kind[m_n] = kind;
      m_addr[m_n] = enq_addr;
    end
    m_n++;
    @(negedge clk);
    enq_valid = 0;
  endtask

  // Returns at the first sampling point where the selection on the new ready state is visible.
  task automatic pulse_ready(logic [N-1:0] m);
    ready_set = m;
    @(negedge clk);
    ready_set = '0;
    @(negedge clk);
  endtask

  task automatic expect_ports(string req, int n, int e0, int e1, int e2, int e3);
    int e [4];
    e = '{e0, e1, e2, e3};
    check(req, "port_valid", int'(port_valid), (1 << n) - 1);
    for (int p = 0; p < n; p++)
      check(req, $sformatf("port%0d tag", p), int'(port_tag[p*TW +: TW]), e[p]);
  endtask

  task automatic t_reset();
    do_reset();
    check("R9", "q_count", int'(q_count), 0);
    check("R9", "port_valid", int'(port_valid), 0);
  endtask

  task automatic t_head_first();
    do_reset();
    for (int i = 0; i < 3; i++) enq(K_LD, LA, 0);
    pulse_ready(16'h0006);
    expect_ports("R1", 0, 0, 0, 0, 0);
    pulse_ready(16'h0001);
    expect_ports("R1", 3, 0, 1, 2, 0);
    check("R6", "q_count after full gather", int'(q_count), 0);
  endtask

  task automatic t_line_filter();
    do_reset();
    enq(K_LD, LA, 0); enq(K_LD, LB, 0); enq(K_LD, LA, 0); enq(K_LD, LA, 0);
    pulse_ready(16'h000F);
    expect_ports("R2", 3, 0, 2, 3, 0);
    check("R2", "port1 addr", int'(port_addr[AW +: AW]), int'(m_addr[2]));
    check("R6", "q_count", int'(q_count), 3);
    @(negedge clk);
    expect_ports("R2", 1, 1, 0, 0, 0);
    check("R6", "q_count", int'(q_count), 0);
  endtask

  task automatic t_barrier();
    do_reset();
    enq(K_LD, LA, 0); enq(K_LD, LA, 0); enq(K_FN, LA, 0); enq(K_LD, LA, 0);
    pulse_ready(16'h000F);
    expect_ports("R3", 2, 0, 1, 0, 0);
    @(negedge clk);
    expect_ports("R3", 0, 0, 0, 0, 0);
    do_reset();
    enq(K_LD, LA, 0); enq(K_ST, LB, 0); enq(K_LD, LA, 0); enq(K_ST, LA, 0); enq(K_LD, LA, 0);
    pulse_ready(16'h001F);
    expect_ports("R3", 2, 0, 2, 0, 0);
  endtask

  task automatic t_saturate();
    do_reset();
    for (int i = 0; i < 6; i++) enq(K_LD, LA, 0);
    pulse_ready(16'h003F);
    expect_ports("R4", 4, 0, 1, 2, 3);
    check("R4", "q_count", int'(q_count), 2);
    @(negedge clk);
    expect_ports("R4", 2, 4, 5, 0, 0);
    check("R6", "q_count", int'(q_count), 0);
  endtask

  task automatic t_skip();
    do_reset();
    enq(K_LD, LA, 0); enq(K_LD, LB, 0); enq(K_LD, LA, 0);
    pulse_ready(16'h0007);
    expect_ports("R5", 2, 0, 2, 0, 0);
    check("R6", "q_count", int'(q_count), 2);
    @(negedge clk);
    expect_ports("R5", 1, 1, 0, 0, 0);
    check("R6", "q_count past removed", int'(q_count), 0);
    @(negedge clk);
    expect_ports("R5", 0, 0, 0, 0, 0);
  endtask

  task automatic t_barrier_issue();
    do_reset();
    enq(K_FN, LA, 0); enq(K_LD, LA, 0);
    pulse_ready(16'h0003);
    expect_ports("R7", 0, 0, 0, 0, 0);
    @(negedge clk);
    expect_ports("R7", 0, 0, 0, 0, 0);
    check("R7", "q_count held", int'(q_count), 2);
    peer_at_barrier = 1;
    @(negedge clk);
    peer_at_barrier = 0;
    expect_ports("R7", 1, 0, 0, 0, 0);
    check("R7", "port0 kind", int'(port_kind[1:0]), K_FN);
    check("R7", "q_count", int'(q_count), 1);
    @(negedge clk);
    expect_ports("R7", 1, 1, 0, 0, 0);
    check("R7", "port0 kind load", int'(port_kind[1:0]), K_LD);
    do_reset();
    peer_at_barrier = 1;
    enq(K_AT, LA, 0);
    pulse_ready(16'h0001);
    peer_at_barrier = 0;
    expect_ports("R7", 1, 0, 0, 0, 0);
    check("R7", "port0 kind atomic", int'(port_kind[1:0]), K_AT);
  endtask

  task automatic t_full();
    do_reset();
    for (int i = 0; i < N; i++) enq(K_LD, LA, 0);
    check("R8", "q_count full", int'(q_count), N);
    enq(K_LD, LA, 1);
    check("R8", "q_count after dropped enqueue", int'(q_count), N);
    pulse_ready(16'hFFFF);
    expect_ports("R8", 4, 0, 1, 2, 3);
    repeat (3) @(negedge clk);
    expect_ports("R8", 4, 12, 13, 14, 15);
    check("R8", "q_count drained", int'(q_count), 0);
    @(negedge clk);
    expect_ports("R8", 0, 0, 0, 0, 0);
  endtask

  // Serial head-to-tail reference against random contents and barriers (R2, R3, R4).
  task automatic t_random(int iters);
    for (int it = 0; it < iters; it++) begin
      int n, ne, r;
      int exp_t [P];
      logic [N-1:0] m;
      logic [AW-1:0] l0;
      do_reset();
      n = 1 + int'($urandom % N);
      for (int i = 0; i < n; i++) begin
        r = int'($urandom % 10);
        enq((r < 6) ? K_LD : (r < 8) ? K_ST : (r < 9) ? K_FN : K_AT, int'($urandom % 3), 0);
      end
      m = N'($urandom);
      pulse_ready(m);
      ne = 0;
      if (m_kind[0] == K_LD && m[0]) begin
        l0 = m_addr[0] >> 6;
        for (int i = 0; i < n; i++) begin
          if (m_kind[i] >= K_FN || (m_kind[i] == K_ST && (m_addr[i] >> 6) == l0)) break;
          if (m_kind[i] == K_LD && m[i] && (m_addr[i] >> 6) == l0 && ne < P) begin
            exp_t[ne] = i;
            ne++;
          end
        end
      end
      check("R3", "random port_valid", int'(port_valid), (1 << ne) - 1);
      for (int p = 0; p < ne; p++) begin
        check("R2", $sformatf("random port%0d tag", p), int'(port_tag[p*TW +: TW]), exp_t[p]);
        check("R2", $sformatf("random port%0d addr", p), int'(port_addr[p*AW +: AW]),
              int'(m_addr[exp_t[p]]));
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R9: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_head_first();
    t_line_filter();
    t_barrier();
    t_saturate();
    t_skip();
    t_barrier_issue();
    t_full();
    t_random(200);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule